// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit forms the memory address for a load or store and the new value of its base register. Each request carries a 32-bit base value and an offset taken either from a 12-bit unsigned immediate or from a second register. The register offset can be moved left by a 5-bit amount, which scales an element index into a byte distance. A direction bit adds the offset to the base or takes it away. Both directions wrap modulo 2^32.

The indexing select chooses which value goes to memory. In the pre-indexed form the access uses the offset sum, and the base is rewritten only when the writeback flag is set. In the post-indexed form the access uses the untouched base, and the base is always replaced by the sum. All results are registered and appear one clock after the request. The register file and the memory port sit outside this unit and consume its outputs.

Top module: `agu_index`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rsp_valid` and `base_we` are 0 and `mem_addr` and `base_next` are 0.
- R2: With `use_reg`=0 the offset is `imm12` zero-extended to 32 bits, and `roff` and `shamt` have no effect.
- R3: With `use_reg`=1 the offset is `roff` shifted left by `shamt` positions (0 to 31), with zeros filling from the bottom and bits above bit 31 dropped; `shamt`=0 uses `roff` as it is.
- R4: `up`=1 gives sum = base + offset and `up`=0 gives sum = base - offset, both modulo 2^32.
- R5: With `pre`=1 the memory address is the sum.
- R6: With `pre`=1 and `wback`=1, `base_we` is 1 and `base_next` equals the sum.
- R7: With `pre`=1 and `wback`=0, `base_we` is 0.
- R8: With `pre`=0 the memory address is the unmodified base, `base_next` is the sum, and `base_we` is 1 whatever `wback` is.
- R9: A request accepted on a clock edge (`req_valid`=1) produces its results with `rsp_valid`=1 after that edge. An edge with `req_valid`=0 gives `rsp_valid`=0 and `base_we`=0, and `mem_addr` and `base_next` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| base | input | 32 | Base register value |
| use_reg | input | 1 | 1: register offset, 0: immediate offset |
| imm12 | input | 12 | Unsigned immediate offset |
| roff | input | 32 | Register offset value |
| shamt | input | 5 | Left shift applied to the register offset |
| up | input | 1 | 1: add offset, 0: subtract offset |
| pre | input | 1 | 1: pre-indexed, 0: post-indexed |
| wback | input | 1 | Writeback request for the pre-indexed form |
| rsp_valid | output | 1 | Results valid |
| mem_addr | output | 32 | Effective memory address |
| base_next | output | 32 | Updated base value |
| base_we | output | 1 | Base register write enable |

## Verification
The bench targets wraparound in both directions: zero minus one has to give all ones, and a carry out of bit 31 has to be dropped. A design that saturates or keeps a 33rd bit would give wrong addresses for these cases. It also drives shift amounts of 0 and 31, and a nonzero shift together with an immediate offset. These cases catch an off-by-one shifter and an offset path that leaks the shift into immediates. Post-indexed requests with writeback cleared, and pre-indexed requests with it set, are checked against the expected write enable. This exposes a design that swaps the base and the sum between the two forms or that lets the flag gate the post-indexed update.

// File: rtl/agu_index.sv
module agu_index #(
  parameter int AW = 32,
  parameter int IW = 12,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] base,
  input  logic          use_reg,
  input  logic [IW-1:0] imm12,
  input  logic [AW-1:0] roff,
  input  logic [SW-1:0] shamt,
  input  logic          up,
  input  logic          pre,
  input  logic          wback,
  output logic          rsp_valid,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] base_next,
  output logic          base_we
);
  localparam int ZW = AW - IW;

  logic [AW-1:0] shifted, offset, sum;

  assign shifted = roff << shamt;
  assign offset  = use_reg ? shifted : {{ZW{1'b0}}, imm12};
  assign sum     = up ? base + offset : base - offset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      base_we   <= 1'b0;
      mem_addr  <= '0;
      base_next <= '0;
    end else begin
      rsp_valid <= req_valid;
      base_we   <= req_valid & (~pre | wback);
      if (req_valid) begin
        mem_addr  <= pre ? sum : base;
        base_next <= sum;
      end
    end
  end
endmodule

// File: rtl/agu_index_chk.sv
module agu_index_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] base,
  input logic        pre,
  input logic        wback,
  input logic        rsp_valid,
  input logic [31:0] mem_addr,
  input logic [31:0] base_next,
  input logic        base_we
);
  p_resp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !base_we && $stable(mem_addr) && $stable(base_next)));
  p_post_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pre) |=> (base_we && mem_addr == $past(base)));
  p_pre_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pre && wback) |=> (base_we && base_next == mem_addr));
  p_pre_nowb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pre && !wback) |=> !base_we);
  p_we_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> rsp_valid);
endmodule

bind agu_index agu_index_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base(base),
  .pre(pre), .wback(wback), .rsp_valid(rsp_valid), .mem_addr(mem_addr),
  .base_next(base_next), .base_we(base_we)
);

// File: tb/agu_index_test.sv
module agu_index_test;
  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [31:0] base = 0, roff = 0;
  logic use_reg = 0, up = 0, pre = 0, wback = 0;
  logic [11:0] imm12 = 0;
  logic [4:0] shamt = 0;
  logic rsp_valid, base_we;
  logic [31:0] mem_addr, base_next;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  agu_index uut (.*);

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_off(logic u, logic [11:0] im, logic [31:0] r, logic [4:0] s);
    return u ? (r << s) : {20'd0, im};
  endfunction

  function automatic logic [31:0] exp_sum(logic [31:0] b, logic [31:0] o, logic a);
    return a ? b + o : b - o;
  endfunction

  task automatic req(string tag, logic [31:0] b, logic u, logic [11:0] im,
                     logic [31:0] r, logic [4:0] s, logic a, logic p, logic w);
    logic [31:0] sm;
    @(negedge clk);
    req_valid = 1; base = b; use_reg = u; imm12 = im; roff = r;
    shamt = s; up = a; pre = p; wback = w;
    sm = exp_sum(b, exp_off(u, im, r, s), a);
    @(posedge clk); #1;
    check(tag, "rsp_valid R9", {31'd0, rsp_valid}, 32'd1);
    check(tag, p ? "addr R5" : "addr R8", mem_addr, p ? sm : b);
    check(tag, "base_next R4", base_next, sm);
    check(tag, p ? (w ? "we R6" : "we R7") : "we R8", {31'd0, base_we}, {31'd0, (!p || w)});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep_a, keep_b;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "rsp_valid in reset", {31'd0, rsp_valid}, 0);
    check("R1", "base_we in reset", {31'd0, base_we}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1", "addr after reset", mem_addr, 0);
    check("R1", "base_next after reset", base_next, 0);
    check("R1", "rsp_valid after reset", {31'd0, rsp_valid}, 0);

    req("R2 imm max", 32'h1000, 0, 12'hFFF, 32'hDEAD, 5'd7, 1, 1, 0);
    req("R2 shamt ignored", 32'h2000, 0, 12'h010, 32'hFFFF_FFFF, 5'd31, 0, 1, 1);
    req("R3 shift 0", 32'h100, 1, 12'h0, 32'h0000_0123, 5'd0, 1, 1, 0);
    req("R3 shift 2", 32'h100, 1, 12'h0, 32'h0000_0008, 5'd2, 1, 0, 0);
    req("R3 shift 31", 32'h0, 1, 12'h0, 32'h0000_0003, 5'd31, 1, 1, 1);
    req("R4 underflow", 32'h0, 0, 12'h001, 32'h0, 5'd0, 0, 1, 1);
    req("R4 overflow", 32'hFFFF_FFF0, 1, 12'h0, 32'h20, 5'd0, 1, 0, 0);
    req("R6 pre wb", 32'h8000, 0, 12'h020, 32'h0, 5'd0, 1, 1, 1);
    req("R7 pre nowb", 32'h8000, 0, 12'h030, 32'h0, 5'd0, 1, 1, 0);
    req("R8 post nowb", 32'h4000, 1, 12'h0, 32'h5, 5'd2, 0, 0, 0);
    req("R8 post wb", 32'h4000, 0, 12'h004, 32'h0, 5'd0, 1, 0, 1);

    keep_a = mem_addr; keep_b = base_next;
    @(negedge clk);
    req_valid = 0; base = 32'h7777_7777; imm12 = 12'hABC; pre = 1; wback = 1;
    @(posedge clk); #1;
    check("R9", "idle rsp_valid", {31'd0, rsp_valid}, 0);
    check("R9", "idle base_we", {31'd0, base_we}, 0);
    check("R9", "idle addr held", mem_addr, keep_a);
    check("R9", "idle base_next held", base_next, keep_b);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] rb, rr, rs;
      rb = $urandom; rr = $urandom; rs = $urandom;
      req("R3 R4 R5 R8 random", rb, rs[0], rs[12:1], rr, rs[17:13], rs[18], rs[19], rs[20]);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule